// File: doc/BRIEF.md
# DDR2 Power-Up Initialization Sequencer

This block brings a DDR2 device from power-on to a usable state without software help. After reset it walks a fixed list of fourteen memory commands: two NOPs around a long power-up wait, precharge-all, the extended and plain mode-register writes (DLL enable, DLL reset, the off-chip-driver calibrate and exit cycles), two auto-refreshes and one dummy write. A programmable number of idle cycles follows each command. Then it raises a one-cycle pulse that tells the following controller to load its refresh rate, and holds its done flag.

Alongside the sequence, the block works out from the geometry inputs which system-address bit selects the bank. It offers that bit position to the rest of the controller, which uses it to aim mode-register writes at the right bank. Configuration inputs must stay constant from reset release until done.

Top module: `ddr2_init_seq`

## Requirements
- R1: `bank_bit_pos` equals col code + 9, plus (row code + 11) only when `cfg_interleave` is 0, plus 1 when `cfg_narrow_bus` is 1 or 2 when it is 0.
- R2: While `rst_n` is low at a rising edge, the next cycle has `cmd_valid`, `init_done` and `refresh_ld` all low. The first command is valid in the cycle after the first rising edge with `rst_n` high.
- R3: The first command is a NOP and the second is a NOP. Exactly `cfg_powerup_wait` idle cycles separate them.
- R4: Commands appear in this order, with the bank on `cmd_ba` shown in brackets: NOP, NOP, PRE, MRS[2], MRS[3], MRS[1], MRS[0], PRE, REF, REF, MRS[0], MRS[1], MRS[1], WRITE. All other commands use bank 0.
- R5: `cmd_code` is {RAS_n, CAS_n, WE_n}: NOP=111, PRE=010, REF=001, MRS=000, WRITE=100. It reads 111 with bank and address 0 whenever `cmd_valid` is low.
- R6: A precharge carries only address bit 10 set. The bank-3 MRS, the NOPs, the refreshes and the write carry address 0. The bank-2 MRS carries `cfg_emr2` unchanged.
- R7: Each bank-1 MRS carries `cfg_emr1` with bit 0 forced to 0 (DLL on). Bits 9..7 are 000 on the first and third such command and 111 on the second.
- R8: The first bank-0 MRS carries `cfg_mr` with bit 8 forced to 1 (DLL reset). The second carries it with bit 8 forced to 0.
- R9: The number of idle cycles after a command is `cfg_trp` for a precharge, `cfg_trfc` for a refresh, and `cfg_tmrd` for the second NOP, any MRS and the write. A value of 0 gives back-to-back commands.
- R10: After the write's `cfg_tmrd` idle cycles, `refresh_ld` is high for exactly one cycle and `init_done` rises with it. `init_done` then stays high, and no command is issued until reset.
- R11: Reset asserted in the middle of the sequence abandons it. The sequence then restarts from the first NOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_col_code | input | COL_W | Column-bits code |
| cfg_row_code | input | ROW_W | Row-bits code |
| cfg_interleave | input | 1 | 1 = interleaved bank decode, 0 = sequential |
| cfg_narrow_bus | input | 1 | 1 = half-width data bus |
| cfg_powerup_wait | input | WAIT_W | Idle cycles after the first NOP (at least 200 us) |
| cfg_trp | input | GAP_W | Idle cycles after a precharge |
| cfg_trfc | input | GAP_W | Idle cycles after a refresh |
| cfg_tmrd | input | GAP_W | Idle cycles after NOP 2, an MRS or the write |
| cfg_mr | input | ADDR_W | Mode-register payload |
| cfg_emr1 | input | ADDR_W | Extended mode register 1 payload (drive strength etc.) |
| cfg_emr2 | input | ADDR_W | Extended mode register 2 payload |
| cmd_valid | output | 1 | Command issued this cycle |
| cmd_code | output | 3 | {RAS_n, CAS_n, WE_n} |
| cmd_ba | output | BA_W | Bank address |
| cmd_addr | output | ADDR_W | Row/address bus |
| bank_bit_pos | output | POS_W | System-address bit that selects the bank |
| refresh_ld | output | 1 | One-cycle pulse: load the refresh rate now |
| init_done | output | 1 | Initialization complete |

## Verification
The bench counts idle cycles between commands for the power-up wait, the precharge, refresh and mode-register gaps. A design that counted one cycle too many or too few, or that picked the wrong gap class, would misplace every later command. Zero gaps are run to catch a sequencer that always inserts a wait cycle. Mode-register payloads are fed with the DLL-reset and calibrate bits already set or already clear, which exposes a design that ORs the bits in instead of forcing them. A reset is issued partway through the sequence; a design that resumed from the current step instead of the first NOP would be caught. The bank-bit position is swept across both decode modes and both bus widths, which catches a row term added in interleaved mode or a swapped bus-width increment.

// File: rtl/ddr2_init_pkg.sv
`timescale 1ns/1ps
// Shared types and the fixed DDR2 power-up command list.
// Assumes the command list is fixed by the DDR2 power-up procedure; only the
// payloads and gap lengths are configurable.
package ddr2_init_pkg;

    // {RAS_n, CAS_n, WE_n}
    typedef enum logic [2:0] {
        CMD_MRS = 3'b000,
        CMD_REF = 3'b001,
        CMD_PRE = 3'b010,
        CMD_WR  = 3'b100,
        CMD_NOP = 3'b111
    } ddr2_cmd_e;

    typedef enum logic [1:0] {
        GAP_POWERUP,
        GAP_RP,
        GAP_RFC,
        GAP_MRD
    } gap_e;

    typedef enum logic [2:0] {
        PL_ZERO,
        PL_PRE_ALL,
        PL_EMR2,
        PL_EMR1_RUN,
        PL_EMR1_OCD_DFLT,
        PL_MR_DLL_RST,
        PL_MR_RUN
    } payload_e;

    typedef struct packed {
        ddr2_cmd_e cmd;
        logic [1:0] bank;
        payload_e payload;
        gap_e gap;
    } step_t;

    localparam int STEP_COUNT  = 14;
    localparam int A10_BIT     = 10;
    localparam int DLL_RST_BIT = 8;
    localparam int OCD_LSB     = 7;
    localparam int DLL_OFF_BIT = 0;

    // Returns the command, bank, payload kind and gap class of one step
    function automatic step_t step_lookup(input logic [3:0] idx);
        step_t s;
        case (idx)
            4'd0:    s = '{CMD_NOP, 2'd0, PL_ZERO,          GAP_POWERUP};
            4'd1:    s = '{CMD_NOP, 2'd0, PL_ZERO,          GAP_MRD};
            4'd2:    s = '{CMD_PRE, 2'd0, PL_PRE_ALL,       GAP_RP};
            4'd3:    s = '{CMD_MRS, 2'd2, PL_EMR2,          GAP_MRD};
            4'd4:    s = '{CMD_MRS, 2'd3, PL_ZERO,          GAP_MRD};
            4'd5:    s = '{CMD_MRS, 2'd1, PL_EMR1_RUN,      GAP_MRD};
            4'd6:    s = '{CMD_MRS, 2'd0, PL_MR_DLL_RST,    GAP_MRD};
            4'd7:    s = '{CMD_PRE, 2'd0, PL_PRE_ALL,       GAP_RP};
            4'd8:    s = '{CMD_REF, 2'd0, PL_ZERO,          GAP_RFC};
            4'd9:    s = '{CMD_REF, 2'd0, PL_ZERO,          GAP_RFC};
            4'd10:   s = '{CMD_MRS, 2'd0, PL_MR_RUN,        GAP_MRD};
            4'd11:   s = '{CMD_MRS, 2'd1, PL_EMR1_OCD_DFLT, GAP_MRD};
            4'd12:   s = '{CMD_MRS, 2'd1, PL_EMR1_RUN,      GAP_MRD};
            default: s = '{CMD_WR,  2'd0, PL_ZERO,          GAP_MRD};
        endcase
        return s;
    endfunction

endpackage

// File: rtl/ddr2_bank_pos.sv
`timescale 1ns/1ps
// Bank-select bit position from the memory geometry.
// The result is combinational; the configuration is assumed static.
module ddr2_bank_pos #(
    parameter int COL_W = 2,
    parameter int ROW_W = 2,
    parameter int POS_W = 5
) (
    input  logic [COL_W-1:0] col_code_i,
    input  logic [ROW_W-1:0] row_code_i,
    input  logic             interleave_i,
    input  logic             narrow_i,
    output logic [POS_W-1:0] pos_o
);
    // Sum the column term, the optional row term and the bus-width term
    always_comb begin
        pos_o = POS_W'(col_code_i) + POS_W'(9);
        if (!interleave_i) begin
            pos_o = pos_o + POS_W'(row_code_i) + POS_W'(11);
        end
        pos_o = pos_o + (narrow_i ? POS_W'(1) : POS_W'(2));
    end
endmodule

// File: rtl/ddr2_gap_timer.sv
`timescale 1ns/1ps
// Loadable down-counter that measures the idle gap after a command.
// last_o is high in the final idle cycle of a gap of length >= 1.
module ddr2_gap_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic             last_o
);
    logic [CNT_W-1:0] cnt_q;

    // Load on a command cycle, otherwise count down to zero
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= load_val_i;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign last_o = (cnt_q == CNT_W'(1));
endmodule

// File: rtl/ddr2_mr_payload.sv
`timescale 1ns/1ps
// Builds the address-bus payload for the current step.
// Forces the DLL-enable, DLL-reset and OCD bits and keeps every other bit
// of the caller's mode-register values. Assumes ADDR_W >= 11.
module ddr2_mr_payload
    import ddr2_init_pkg::*;
#(
    parameter int ADDR_W = 14
) (
    input  payload_e          kind_i,
    input  logic [ADDR_W-1:0] mr_i,
    input  logic [ADDR_W-1:0] emr1_i,
    input  logic [ADDR_W-1:0] emr2_i,
    output logic [ADDR_W-1:0] addr_o
);
    // Select a base word and override the bits that the sequence owns
    always_comb begin
        addr_o = '0;
        case (kind_i)
            PL_PRE_ALL: addr_o[A10_BIT] = 1'b1;
            PL_EMR2:    addr_o = emr2_i;
            PL_EMR1_RUN: begin
                addr_o = emr1_i;
                addr_o[DLL_OFF_BIT] = 1'b0;
                addr_o[OCD_LSB +: 3] = 3'b000;
            end
            PL_EMR1_OCD_DFLT: begin
                addr_o = emr1_i;
                addr_o[DLL_OFF_BIT] = 1'b0;
                addr_o[OCD_LSB +: 3] = 3'b111;
            end
            PL_MR_DLL_RST: begin
                addr_o = mr_i;
                addr_o[DLL_RST_BIT] = 1'b1;
            end
            PL_MR_RUN: begin
                addr_o = mr_i;
                addr_o[DLL_RST_BIT] = 1'b0;
            end
            default: addr_o = '0;
        endcase
    end
endmodule

// File: rtl/ddr2_init_seq.sv
`timescale 1ns/1ps
// DDR2 power-up sequencer top. It steps through the fixed command list,
// issuing one command per step, then waits that step's gap. When the list
// ends it pulses refresh_ld and holds init_done until reset.
// Assumes the configuration is static from reset release to done and that
// WAIT_W >= GAP_W.
module ddr2_init_seq
    import ddr2_init_pkg::*;
#(
    parameter int COL_W  = 2,
    parameter int ROW_W  = 2,
    parameter int ADDR_W = 14,
    parameter int BA_W   = 3,
    parameter int GAP_W  = 8,
    parameter int WAIT_W = 16,
    localparam int POS_W = $clog2((1 << COL_W) + (1 << ROW_W) + 21)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [COL_W-1:0]  cfg_col_code,
    input  logic [ROW_W-1:0]  cfg_row_code,
    input  logic              cfg_interleave,
    input  logic              cfg_narrow_bus,
    input  logic [WAIT_W-1:0] cfg_powerup_wait,
    input  logic [GAP_W-1:0]  cfg_trp,
    input  logic [GAP_W-1:0]  cfg_trfc,
    input  logic [GAP_W-1:0]  cfg_tmrd,
    input  logic [ADDR_W-1:0] cfg_mr,
    input  logic [ADDR_W-1:0] cfg_emr1,
    input  logic [ADDR_W-1:0] cfg_emr2,
    output logic              cmd_valid,
    output logic [2:0]        cmd_code,
    output logic [BA_W-1:0]   cmd_ba,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic [POS_W-1:0]  bank_bit_pos,
    output logic              refresh_ld,
    output logic              init_done
);
    localparam logic [3:0] LAST_STEP = 4'(STEP_COUNT - 1);

    typedef enum logic [2:0] {ST_IDLE, ST_ISSUE, ST_WAIT, ST_LOAD, ST_DONE} state_e;

    state_e            state_q;
    logic [3:0]        step_q;
    step_t             cur;
    logic [WAIT_W-1:0] gap_val;
    logic              timer_last;
    logic              advance;
    logic [ADDR_W-1:0] payload;

    ddr2_bank_pos #(.COL_W(COL_W), .ROW_W(ROW_W), .POS_W(POS_W)) u_pos (
        .col_code_i   (cfg_col_code),
        .row_code_i   (cfg_row_code),
        .interleave_i (cfg_interleave),
        .narrow_i     (cfg_narrow_bus),
        .pos_o        (bank_bit_pos)
    );

    ddr2_gap_timer #(.CNT_W(WAIT_W)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (state_q == ST_ISSUE),
        .load_val_i (gap_val),
        .last_o     (timer_last)
    );

    ddr2_mr_payload #(.ADDR_W(ADDR_W)) u_payload (
        .kind_i (cur.payload),
        .mr_i   (cfg_mr),
        .emr1_i (cfg_emr1),
        .emr2_i (cfg_emr2),
        .addr_o (payload)
    );

    // Decode the current step
    assign cur = step_lookup(step_q);

    // Pick the idle-gap length for the current step's gap class
    always_comb begin
        case (cur.gap)
            GAP_POWERUP: gap_val = cfg_powerup_wait;
            GAP_RP:      gap_val = WAIT_W'(cfg_trp);
            GAP_RFC:     gap_val = WAIT_W'(cfg_trfc);
            default:     gap_val = WAIT_W'(cfg_tmrd);
        endcase
    end

    // A step finishes after its command when there is no gap, else on the gap's last cycle
    assign advance = ((state_q == ST_ISSUE) && (gap_val == '0)) ||
                     ((state_q == ST_WAIT) && timer_last);

    // Sequencer state and step index
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            step_q  <= '0;
        end else begin
            case (state_q)
                ST_IDLE: state_q <= ST_ISSUE;
                ST_ISSUE, ST_WAIT: begin
                    if (advance) begin
                        if (step_q == LAST_STEP) begin
                            state_q <= ST_LOAD;
                        end else begin
                            step_q  <= step_q + 1'b1;
                            state_q <= ST_ISSUE;
                        end
                    end else begin
                        state_q <= ST_WAIT;
                    end
                end
                ST_LOAD: state_q <= ST_DONE;
                default: state_q <= ST_DONE;
            endcase
        end
    end

    // Drive the command bus only in a command cycle, NOP otherwise
    always_comb begin
        cmd_valid = (state_q == ST_ISSUE);
        cmd_code  = CMD_NOP;
        cmd_ba    = '0;
        cmd_addr  = '0;
        if (cmd_valid) begin
            cmd_code = cur.cmd;
            cmd_ba   = BA_W'(cur.bank);
            cmd_addr = payload;
        end
    end

    assign refresh_ld = (state_q == ST_LOAD);
    assign init_done  = (state_q == ST_LOAD) || (state_q == ST_DONE);
endmodule

// File: rtl/ddr2_init_seq_chk.sv
`timescale 1ns/1ps
// Protocol checker for ddr2_init_seq, attached with bind.
module ddr2_init_seq_chk #(
    parameter int COL_W  = 2,
    parameter int ROW_W  = 2,
    parameter int ADDR_W = 14,
    parameter int BA_W   = 3,
    parameter int GAP_W  = 8,
    parameter int POS_W  = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic [GAP_W-1:0]  cfg_trfc,
    input logic              cmd_valid,
    input logic [2:0]        cmd_code,
    input logic [BA_W-1:0]   cmd_ba,
    input logic [ADDR_W-1:0] cmd_addr,
    input logic [POS_W-1:0]  bank_bit_pos,
    input logic              refresh_ld,
    input logic              init_done
);
    localparam int POS_MAX = (1 << COL_W) - 1 + (1 << ROW_W) - 1 + 22;

    assert_pos_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(bank_bit_pos) >= 10) && (int'(bank_bit_pos) <= POS_MAX));

    assert_reset_quiet_R2: assert property (@(posedge clk)
        !rst_n |=> (!cmd_valid && !init_done && !refresh_ld));

    assert_legal_code_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> (cmd_code inside {3'b000, 3'b001, 3'b010, 3'b100, 3'b111}));

    assert_pre_a10_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_code == 3'b010) |-> cmd_addr[10]);

    assert_emr3_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_code == 3'b000 && cmd_ba == BA_W'(3)) |-> (cmd_addr == '0));

    assert_ref_gap_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_code == 3'b001 && cfg_trfc != '0) |=> !cmd_valid);

    assert_done_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |=> init_done);

    assert_quiet_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |-> !cmd_valid);

    assert_ld_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        refresh_ld |=> !refresh_ld);

    assert_ld_first_R10: assert property (@(posedge clk) disable iff (!rst_n)
        refresh_ld |-> (init_done && $rose(init_done)));
endmodule

bind ddr2_init_seq ddr2_init_seq_chk #(
    .COL_W(COL_W), .ROW_W(ROW_W), .ADDR_W(ADDR_W),
    .BA_W(BA_W), .GAP_W(GAP_W), .POS_W(POS_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_trfc     (cfg_trfc),
    .cmd_valid    (cmd_valid),
    .cmd_code     (cmd_code),
    .cmd_ba       (cmd_ba),
    .cmd_addr     (cmd_addr),
    .bank_bit_pos (bank_bit_pos),
    .refresh_ld   (refresh_ld),
    .init_done    (init_done)
);

// File: tb/ddr2_init_seq_test.sv
`timescale 1ns/1ps
// Directed bench for ddr2_init_seq: one task per scenario.
module ddr2_init_seq_test;
    localparam int ADDR_W = 14;
    localparam int WAIT_W = 16;
    localparam int GAP_W  = 8;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic              rst_n = 1'b0;
    logic [1:0]        col = '0, row = '0;
    logic              ilv = 1'b0, narrow = 1'b0;
    logic [WAIT_W-1:0] pwait = '0;
    logic [GAP_W-1:0]  trp = '0, trfc = '0, tmrd = '0;
    logic [ADDR_W-1:0] mr = '0, emr1 = '0, emr2 = '0;

    logic              cmd_valid, refresh_ld, init_done;
    logic [2:0]        cmd_code;
    logic [2:0]        cmd_ba;
    logic [ADDR_W-1:0] cmd_addr;
    logic [4:0]        bank_bit_pos;

    int  checks = 0;
    int  errors = 0;
    bit  finished = 1'b0;

    ddr2_init_seq uut (
        .clk(clk), .rst_n(rst_n), .cfg_col_code(col), .cfg_row_code(row),
        .cfg_interleave(ilv), .cfg_narrow_bus(narrow), .cfg_powerup_wait(pwait),
        .cfg_trp(trp), .cfg_trfc(trfc), .cfg_tmrd(tmrd), .cfg_mr(mr),
        .cfg_emr1(emr1), .cfg_emr2(emr2), .cmd_valid(cmd_valid),
        .cmd_code(cmd_code), .cmd_ba(cmd_ba), .cmd_addr(cmd_addr),
        .bank_bit_pos(bank_bit_pos), .refresh_ld(refresh_ld), .init_done(init_done)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Expected command code per step (R4, R5)
    function automatic int exp_code(input int i);
        case (i)
            0, 1:   return 7;
            2, 7:   return 2;
            8, 9:   return 1;
            13:     return 4;
            default: return 0;
        endcase
    endfunction

    // Expected bank per step (R4)
    function automatic int exp_ba(input int i);
        case (i)
            3:          return 2;
            4:          return 3;
            5, 11, 12:  return 1;
            default:    return 0;
        endcase
    endfunction

    // Expected address payload per step (R6, R7, R8)
    function automatic logic [ADDR_W-1:0] exp_addr(input int i);
        logic [ADDR_W-1:0] a;
        a = '0;
        case (i)
            2, 7: a[10] = 1'b1;
            3:    a = emr2;
            5, 12: begin a = emr1; a[0] = 1'b0; a[9:7] = 3'b000; end
            11:    begin a = emr1; a[0] = 1'b0; a[9:7] = 3'b111; end
            6:     begin a = mr; a[8] = 1'b1; end
            10:    begin a = mr; a[8] = 1'b0; end
            default: a = '0;
        endcase
        return a;
    endfunction

    function automatic string addr_req(input int i);
        case (i)
            5, 11, 12: return "R7";
            6, 10:     return "R8";
            default:   return "R6";
        endcase
    endfunction

    // Idle cycles expected before event i (event 14 is the refresh_ld pulse) (R3, R9)
    function automatic int exp_gap(input int i);
        case (i - 1)
            0:       return int'(pwait);
            2, 7:    return int'(trp);
            8, 9:    return int'(trfc);
            default: return int'(tmrd);
        endcase
    endfunction

    // Hold reset for three cycles and check the quiet outputs (R2)
    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check(!cmd_valid && !init_done && !refresh_ld, "R2", "outputs in reset",
              {cmd_valid, init_done, refresh_ld}, 0);
        rst_n = 1'b1;
    endtask

    // Reset, then capture and check the whole sequence (R3..R10)
    task automatic run_full(input string name);
        int idx = 0;
        int idle = 0;
        int cyc = 0;
        bit got_ld = 1'b0;
        bit quiet = 1'b1;
        do_reset();
        while (!got_ld && cyc < 20000) begin
            @(negedge clk);
            cyc++;
            if (cmd_valid) begin
                if (idx < 14) begin
                    check(int'(cmd_code) == exp_code(idx), "R4", {name, " code"},
                          int'(cmd_code), exp_code(idx));
                    check(int'(cmd_ba) == exp_ba(idx), "R4", {name, " bank"},
                          int'(cmd_ba), exp_ba(idx));
                    check(cmd_addr == exp_addr(idx), addr_req(idx), {name, " addr"},
                          int'(cmd_addr), int'(exp_addr(idx)));
                    if (idx == 0)
                        check(idle == 0, "R2", {name, " first cmd delay"}, idle, 0);
                    else
                        check(idle == exp_gap(idx), (idx == 1) ? "R3" : "R9",
                              {name, " gap"}, idle, exp_gap(idx));
                end else begin
                    check(1'b0, "R4", {name, " extra command"}, idx, 13);
                end
                idx++;
                idle = 0;
            end else if (refresh_ld) begin
                got_ld = 1'b1;
                check(idx == 14, "R10", {name, " command count"}, idx, 14);
                check(idle == exp_gap(14), "R10", {name, " load gap"}, idle, exp_gap(14));
                check(init_done, "R10", {name, " done with load"}, int'(init_done), 1);
            end else begin
                if (cmd_code != 3'b111 || cmd_addr != '0 || cmd_ba != '0) quiet = 1'b0;
                idle++;
            end
        end
        check(got_ld, "R10", {name, " reached load"}, int'(got_ld), 1);
        check(quiet, "R5", {name, " idle bus is NOP"}, int'(quiet), 1);
        quiet = 1'b1;
        repeat (20) begin
            @(negedge clk);
            if (cmd_valid || !init_done || refresh_ld) quiet = 1'b0;
        end
        check(quiet, "R10", {name, " quiet and done after load"}, int'(quiet), 1);
    endtask

    // Bank-bit position over both decode modes and bus widths (R1)
    task automatic test_bank_pos();
        for (int c = 0; c < 4; c++) begin
            for (int m = 0; m < 4; m++) begin
                int r = (c + m) % 4;
                int e;
                @(negedge clk);
                col = 2'(c); row = 2'(r); ilv = m[0]; narrow = m[1];
                e = c + 9 + (m[0] ? 0 : r + 11) + (m[1] ? 1 : 2);
                #1;
                check(int'(bank_bit_pos) == e, "R1", "bank bit position",
                      int'(bank_bit_pos), e);
            end
        end
    endtask

    // Sequential decode, non-zero gaps, DLL-reset bit clear in the base word
    task automatic test_seq_gaps();
        col = 2'd1; row = 2'd2; ilv = 1'b0; narrow = 1'b0;
        pwait = 16'd6; trp = 8'd2; trfc = 8'd3; tmrd = 8'd1;
        mr = 14'h0A52; emr1 = 14'h0046; emr2 = 14'h0080;
        run_full("seq_gaps");
    endtask

    // Zero gaps, bits that the sequence forces already set in the base words
    task automatic test_zero_gaps();
        col = 2'd3; row = 2'd0; ilv = 1'b1; narrow = 1'b1;
        pwait = 16'd1; trp = 8'd0; trfc = 8'd0; tmrd = 8'd0;
        mr = 14'h0163; emr1 = 14'h03C3; emr2 = 14'h0000;
        run_full("zero_gaps");
    endtask

    // Reset partway through, then a full run from the first NOP (R11)
    task automatic test_mid_reset();
        int seen = 0;
        int cyc = 0;
        pwait = 16'd20; trp = 8'd4; trfc = 8'd7; tmrd = 8'd3;
        mr = 14'h1234; emr1 = 14'h2001; emr2 = 14'h0F0F;
        do_reset();
        while (seen < 6 && cyc < 2000) begin
            @(negedge clk);
            cyc++;
            if (cmd_valid) seen++;
        end
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(cmd_valid && cmd_code == 3'b111 && !init_done, "R11", "restart at first NOP",
              int'(cmd_code), 7);
        run_full("mid_reset");
    endtask

    initial begin
        #(20 * 200000);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL R10 watchdog: actual hung expected done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        test_bank_pos();
        test_seq_gaps();
        test_zero_gaps();
        test_mid_reset();
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule